// File: doc/BRIEF.md
# 100BASE-X Receive Framer and Error Detector

This block sits after symbol alignment and descrambling in a 100 Mb/s receive path. It takes one aligned 5-bit code group per nibble clock, sorts each group into a class (data, start delimiters, end delimiters, idle or undefined), and runs a small framing state machine. From these it produces the media-independent receive outputs: a data nibble, a data-valid flag and an error flag. All outputs are registered. Each one reflects the code group sampled on the previous rising clock edge.

A frame opens on the two-group start pair. The pair itself appears on the data nibble as one preamble nibble. A frame closes cleanly on the two-group end pair. It closes abnormally on an idle group, which is flagged. A broken delimiter pair or an undefined group raises the error flag for one cycle. A mode input selects 10 Mb/s operation. In that mode, data-valid copies a carrier-sense input and the framer stays parked.

Top module: `rx_framer_top`

## Requirements
- R1: While the synchronous reset is high, the next clock edge drives rxValid, rxError and rxData to zero and returns the framer to its out-of-frame state.
- R2: In 100 Mb/s mode, code group 11000 followed by code group 10001 opens a frame. rxValid stays low for the 11000 cycle. rxValid rises for the 10001 cycle, with rxData = 0x5.
- R3: Inside a frame, each data code group sets rxValid high and puts its nibble on rxData, with rxError low. The mapping is: 11110→0, 01001→1, 10100→2, 10101→3, 01010→4, 01011→5, 01110→6, 01111→7, 10010→8, 10011→9, 10110→A, 10111→B, 11010→C, 11011→D, 11100→E, 11101→F.
- R4: Inside a frame, code group 01101 drops rxValid for its own cycle. If 00111 follows, the frame ends with rxError low throughout.
- R5: If 01101 ends a frame and the next group is not 00111, rxError is high for that next cycle and rxValid stays low.
- R6: If 11000 seen out of frame is followed by anything other than 10001, rxError is high for that second cycle and no frame opens.
- R7: An idle group 11111 inside a frame drops rxValid and raises rxError for that cycle. The framer then returns to out-of-frame.
- R8: A code group that is neither data nor one of 11000, 10001, 01101, 00111, 11111 raises rxError for its cycle in any state. Inside a frame, such a group, or a stray 11000, 10001 or 00111, keeps rxValid high with rxData = 0 and rxError high, and the frame continues.
- R9: With speedTen high, rxValid equals the carrierSense value from the previous edge, rxError and rxData stay zero, and the framer is held out of frame.
- R10: Out of frame, defined code groups other than 11000 cause no output: rxValid, rxError and rxData stay zero. rxData is zero whenever rxValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst | input | 1 | Synchronous reset, active high |
| speedTen | input | 1 | 1 selects 10 Mb/s mode |
| carrierSense | input | 1 | Carrier sense used in 10 Mb/s mode |
| codeIn | input | 5 | Aligned code group |
| rxData | output | 4 | Received nibble |
| rxValid | output | 1 | Receive data valid |
| rxError | output | 1 | Receive error |

## Verification
The bench targets these cases:
- A start group followed by idle. A design that treats the start group alone as a frame opener would raise valid here without flagging an error.
- An end group followed by a non-end group. A design that closes the frame on the first end group alone would miss this error.
- Idle arriving in the middle of a frame. A design that treats it as a normal close would leave the error flag low.
- Stray delimiters and undefined groups inside a frame. These must flag an error without ending the frame.
- Mode switches in both directions in the middle of a frame. These expose any framing state left behind from the earlier mode.

// File: rtl/rx_framer_pkg.sv
package rx_framer_pkg;
  localparam int SYM_W = 5;
  localparam int NIB_W = 4;
  localparam logic [SYM_W-1:0] SYM_START1 = 5'b11000;
  localparam logic [SYM_W-1:0] SYM_START2 = 5'b10001;
  localparam logic [SYM_W-1:0] SYM_END1   = 5'b01101;
  localparam logic [SYM_W-1:0] SYM_END2   = 5'b00111;
  localparam logic [SYM_W-1:0] SYM_IDLE   = 5'b11111;
  localparam logic [NIB_W-1:0] PRE_NIB    = 4'h5;

  typedef enum logic [2:0] {
    CL_DATA, CL_START1, CL_START2, CL_END1, CL_END2, CL_IDLE, CL_BAD
  } codeClass_t;

  typedef enum logic [1:0] {DS_ZERO, DS_NIB, DS_PRE} dataSel_t;

  typedef struct packed {
    logic     validNext;
    dataSel_t sel;
    logic     errNext;
    logic     useCrs;
  } strobes_t;

  function automatic logic [NIB_W:0] decodeData(input logic [SYM_W-1:0] c);
    logic [NIB_W:0] r;
    case (c)
      5'b11110: r = {1'b1, 4'h0};
      5'b01001: r = {1'b1, 4'h1};
      5'b10100: r = {1'b1, 4'h2};
      5'b10101: r = {1'b1, 4'h3};
      5'b01010: r = {1'b1, 4'h4};
      5'b01011: r = {1'b1, 4'h5};
      5'b01110: r = {1'b1, 4'h6};
      5'b01111: r = {1'b1, 4'h7};
      5'b10010: r = {1'b1, 4'h8};
      5'b10011: r = {1'b1, 4'h9};
      5'b10110: r = {1'b1, 4'hA};
      5'b10111: r = {1'b1, 4'hB};
      5'b11010: r = {1'b1, 4'hC};
      5'b11011: r = {1'b1, 4'hD};
      5'b11100: r = {1'b1, 4'hE};
      5'b11101: r = {1'b1, 4'hF};
      default:  r = '0;
    endcase
    return r;
  endfunction

  function automatic codeClass_t classify(input logic [SYM_W-1:0] c);
    codeClass_t k;
    if (decodeData(c)[NIB_W])  k = CL_DATA;
    else if (c == SYM_START1)  k = CL_START1;
    else if (c == SYM_START2)  k = CL_START2;
    else if (c == SYM_END1)    k = CL_END1;
    else if (c == SYM_END2)    k = CL_END2;
    else if (c == SYM_IDLE)    k = CL_IDLE;
    else                       k = CL_BAD;
    return k;
  endfunction
endpackage

// File: rtl/rx_framer_ctrl.sv
module rx_framer_ctrl
  import rx_framer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       speedTen,
  input  codeClass_t cls,
  output strobes_t   ctl
);
  typedef enum logic [1:0] {ST_OUT, ST_GOT_START, ST_FRAME, ST_GOT_END} state_t;
  state_t state, nextState;

  always_comb begin
    nextState     = state;
    ctl.validNext = 1'b0;
    ctl.sel       = DS_ZERO;
    ctl.errNext   = 1'b0;
    ctl.useCrs    = speedTen;
    if (speedTen) begin
      nextState = ST_OUT;
    end else begin
      case (state)
        ST_OUT: begin
          if (cls == CL_START1)   nextState = ST_GOT_START;
          else if (cls == CL_BAD) ctl.errNext = 1'b1;
        end
        ST_GOT_START: begin
          if (cls == CL_START2) begin
            ctl.validNext = 1'b1;
            ctl.sel       = DS_PRE;
            nextState     = ST_FRAME;
          end else begin
            ctl.errNext = 1'b1;
            nextState   = ST_OUT;
          end
        end
        ST_FRAME: begin
          case (cls)
            CL_DATA: begin
              ctl.validNext = 1'b1;
              ctl.sel       = DS_NIB;
            end
            CL_END1: nextState = ST_GOT_END;
            CL_IDLE: begin
              ctl.errNext = 1'b1;
              nextState   = ST_OUT;
            end
            default: begin
              ctl.validNext = 1'b1;
              ctl.errNext   = 1'b1;
            end
          endcase
        end
        default: begin
          if (cls != CL_END2) ctl.errNext = 1'b1;
          nextState = ST_OUT;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_OUT;
    else     state <= nextState;
  end

  AST_START_PAIR_OPENS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GOT_START && cls == CL_START2 && !speedTen) |=> state == ST_FRAME); // R2
  AST_END_PAIR_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GOT_END) |=> state == ST_OUT); // R4
  AST_TEN_PARKS: assert property (@(posedge clk) disable iff (rst)
    speedTen |=> state == ST_OUT); // R9
endmodule

// File: rtl/rx_framer_dp.sv
module rx_framer_dp
  import rx_framer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SYM_W-1:0] codeIn,
  input  logic             carrierSense,
  input  strobes_t         ctl,
  output codeClass_t       cls,
  output logic [NIB_W-1:0] rxData,
  output logic             rxValid,
  output logic             rxError
);
  logic [NIB_W:0] dec;

  always_comb begin
    dec = decodeData(codeIn);
    cls = classify(codeIn);
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.useCrs) begin
      rxData  <= '0;
      rxValid <= ctl.useCrs && !rst && carrierSense;
      rxError <= 1'b0;
    end else begin
      rxValid <= ctl.validNext;
      rxError <= ctl.errNext;
      case (ctl.sel)
        DS_NIB:  rxData <= dec[NIB_W-1:0];
        DS_PRE:  rxData <= PRE_NIB;
        default: rxData <= '0;
      endcase
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!rxValid && !rxError && rxData == '0)); // R1
  AST_IDLE_DROPS_VALID: assert property (@(posedge clk) disable iff (rst)
    (!ctl.useCrs && cls == CL_IDLE) |=> !rxValid); // R7
  AST_BAD_SYMBOL_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (!ctl.useCrs && cls == CL_BAD) |=> rxError); // R8
  AST_TEN_FOLLOWS_CRS: assert property (@(posedge clk) disable iff (rst)
    ctl.useCrs |=> (rxValid == $past(carrierSense) && !rxError)); // R9
  AST_QUIET_DATA: assert property (@(posedge clk) disable iff (rst)
    !rxValid |-> rxData == '0); // R10
endmodule

// File: rtl/rx_framer_top.sv
module rx_framer_top
  import rx_framer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             speedTen,
  input  logic             carrierSense,
  input  logic [SYM_W-1:0] codeIn,
  output logic [NIB_W-1:0] rxData,
  output logic             rxValid,
  output logic             rxError
);
  strobes_t   ctl;
  codeClass_t cls;

  rx_framer_ctrl uCtrl (
    .clk(clk), .rst(rst), .speedTen(speedTen), .cls(cls), .ctl(ctl)
  );

  rx_framer_dp uDp (
    .clk(clk), .rst(rst), .codeIn(codeIn), .carrierSense(carrierSense),
    .ctl(ctl), .cls(cls), .rxData(rxData), .rxValid(rxValid), .rxError(rxError)
  );
endmodule

// File: tb/tb_rx_framer_top.sv
module tb_rx_framer_top;
  logic clk = 1'b0;
  logic rst, speedTen, carrierSense;
  logic [4:0] codeIn;
  logic [3:0] rxData;
  logic rxValid, rxError;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  rx_framer_top dut (
    .clk(clk), .rst(rst), .speedTen(speedTen), .carrierSense(carrierSense),
    .codeIn(codeIn), .rxData(rxData), .rxValid(rxValid), .rxError(rxError)
  );

  always #10 clk = ~clk;

  logic [4:0] tab [16] = '{5'h1E, 5'h09, 5'h14, 5'h15, 5'h0A, 5'h0B, 5'h0E, 5'h0F,
                           5'h12, 5'h13, 5'h16, 5'h17, 5'h1A, 5'h1B, 5'h1C, 5'h1D};
  localparam logic [4:0] JJ = 5'b11000, KK = 5'b10001, TT = 5'b01101,
                         RR = 5'b00111, II = 5'b11111;

  bit mFrame, mSawJ, mSawT;
  logic expV, expE;
  logic [3:0] expD;
  string tag;

  function automatic int nibOf(input logic [4:0] c);
    for (int i = 0; i < 16; i++) if (tab[i] == c) return i;
    return -1;
  endfunction

  function automatic bit known(input logic [4:0] c);
    return nibOf(c) >= 0 || c == JJ || c == KK || c == TT || c == RR || c == II;
  endfunction

  task automatic model(input logic [4:0] c, input logic t, input logic cs, input logic r);
    int n;
    n = nibOf(c);
    expV = 0; expE = 0; expD = 0;
    if (r) begin
      mFrame = 0; mSawJ = 0; mSawT = 0; tag = "R1";
    end else if (t) begin
      mFrame = 0; mSawJ = 0; mSawT = 0; expV = cs; tag = "R9";
    end else if (mSawJ) begin
      mSawJ = 0;
      if (c == KK) begin expV = 1; expD = 4'h5; mFrame = 1; tag = "R2"; end
      else begin expE = 1; tag = "R6"; end
    end else if (mSawT) begin
      mSawT = 0;
      if (c == RR) tag = "R4";
      else begin expE = 1; tag = "R5"; end
    end else if (mFrame) begin
      if (n >= 0) begin expV = 1; expD = n[3:0]; tag = "R3"; end
      else if (c == TT) begin mFrame = 0; mSawT = 1; tag = "R4"; end
      else if (c == II) begin mFrame = 0; expE = 1; tag = "R7"; end
      else begin expV = 1; expE = 1; tag = "R8"; end
    end else begin
      if (c == JJ) begin mSawJ = 1; tag = "R2"; end
      else if (!known(c)) begin expE = 1; tag = "R8"; end
      else tag = "R10";
    end
  endtask

  task automatic cyc(input logic [4:0] c, input logic t = 0, input logic cs = 0,
                     input logic r = 0);
    @(negedge clk);
    checks++;
    if (rxValid !== expV || rxError !== expE || rxData !== expD) begin
      fails++;
      $display("FAIL %s: got v=%b e=%b d=%h, expected v=%b e=%b d=%h",
               tag, rxValid, rxError, rxData, expV, expE, expD);
    end
    codeIn = c; speedTen = t; carrierSense = cs; rst = r;
    model(c, t, cs, r);
  endtask

  task automatic sendNib(input int n);
    cyc(tab[n]);
  endtask

  initial begin
    codeIn = II; speedTen = 0; carrierSense = 0; rst = 1;
    model(II, 0, 0, 1);
    cyc(II, 0, 0, 1);
    cyc(II);                       // R1 reset state observed
    cyc(II); cyc(tab[3]); cyc(RR); // R10 quiet out of frame
    // R2 R3 R4: clean frame with all sixteen nibbles
    cyc(JJ); cyc(KK);
    for (int i = 0; i < 16; i++) sendNib(i);
    cyc(TT); cyc(RR); cyc(II);
    // R6: start group not followed by its partner
    cyc(JJ); cyc(II); cyc(II);
    cyc(JJ); cyc(JJ); cyc(KK); cyc(II);
    // R5: end group followed by idle
    cyc(JJ); cyc(KK); sendNib(10); cyc(TT); cyc(II); cyc(II);
    // R7: idle in mid-frame
    cyc(JJ); cyc(KK); sendNib(7); cyc(II); sendNib(2); cyc(II);
    // R8: undefined and stray groups in frame, and undefined out of frame
    cyc(5'b00000); cyc(5'b00100);
    cyc(JJ); cyc(KK); cyc(5'b00001); sendNib(9); cyc(KK); cyc(JJ); cyc(RR);
    sendNib(15); cyc(TT); cyc(RR);
    // R9: 10 Mb/s mode, including entry mid-frame
    cyc(JJ); cyc(KK); sendNib(4);
    cyc(tab[1], 1, 1); cyc(5'b00000, 1, 1); cyc(JJ, 1, 0); cyc(KK, 1, 1);
    cyc(II, 1, 0); cyc(KK, 0, 1); sendNib(6);
    cyc(JJ); cyc(KK); sendNib(12); cyc(II, 1, 1); cyc(II, 0, 0);
    // R1: reset mid-frame
    cyc(JJ); cyc(KK); sendNib(8); cyc(tab[8], 0, 0, 1); sendNib(8); cyc(II);
    cyc(II);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule